// File: doc/BRIEF.md
# Raster Frame Timing Generator

This block sequences the raster of a tile-based video processor whose dot clock runs at three times the CPU clock. It keeps the dot and scanline counters, marks the visible area and the prerender line, and owns the vertical-blank status flag and the active-low NMI line. It also issues a one-cycle pulse that clears the sprite-hit flag. The counters advance by one position on each clock in which `dot_en` is high.

With the default geometry a line is 341 dots and a frame is 262 lines. At three dots per CPU clock, one line is 113 and 2/3 CPU cycles. Lines 0 to 239 are visible. The vertical-blank flag is high for 20 full lines. On every second frame, when rendering is enabled, the prerender line is one dot shorter. Over two frames this keeps the average frame length in step with the CPU clock.

A read of the status register clears the flag. The NMI output follows the logical AND of the flag and the enable bit. It therefore reacts at once when the enable bit is set in the middle of vertical blank.

Top module: `frame_timing_gen`

## Requirements
- R1: `dot` advances by one on each clock with `dot_en` high, wraps from DOTS-1 to 0 (incrementing `line`), and holds, together with `line`, on clocks with `dot_en` low.
- R2: `line` runs 0 to LINES-1 and wraps to 0. `visible` is high for lines 0 to VIS_LINES-1. `prerender` is high only on line LINES-1.
- R3: While `rst_n` is low, and on its release, `dot`=0, `line`=0, `vblank`=0, `nmi_n`=1 and `hit_clr`=0, and the next frame counts as even.
- R4: `vblank` goes to 1 on the same clock edge that moves the counters to line VIS_LINES+1, dot 1.
- R5: `vblank` goes to 0 on the edge that moves the counters to line LINES-1, dot 1. On that same edge `hit_clr` pulses high for exactly one clock.
- R6: A clock with `status_rd` high clears `vblank`. If the set event of R4 falls on that same edge, the set wins and `vblank` stays 1.
- R7: `nmi_n` is low exactly while `vblank` and `nmi_en` are both 1. It is combinational from the enable, so raising `nmi_en` during vertical blank asserts it in the same cycle.
- R8: Frames alternate even/odd, starting even after reset. An odd frame with `render_en` high skips dot DOTS-1 of the prerender line and lasts DOTS*LINES-1 dot ticks. Every other frame lasts DOTS*LINES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot enable, one raster position per high clock |
| render_en | input | 1 | Rendering enabled; allows the odd-frame skip |
| nmi_en | input | 1 | NMI enable bit |
| status_rd | input | 1 | Status register read strobe |
| dot | output | DOT_W | Current dot within the line |
| line | output | LINE_W | Current scanline |
| visible | output | 1 | Current line is in the picture area |
| prerender | output | 1 | Current line is the prerender line |
| vblank | output | 1 | Vertical-blank status flag |
| hit_clr | output | 1 | One-cycle pulse clearing the sprite-hit flag |
| nmi_n | output | 1 | Active-low NMI request |

## Verification
A wrong frame-parity bit or a mis-decoded skip condition does not change any single position. It shows only as a frame one dot too long or too short, and only two frames later. The bench therefore measures whole frame lengths under both settings of `render_en`. A flag decoder keyed off the wrong counter value shows within one dot of the intended position, as `vblank` or `hit_clr` moving at a neighbouring dot. Every set and clear point is sampled at that exact position and at the one before it. NMI faults show in the same cycle as the enable change, so they are sampled before any clock edge.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
   // raster events decoded from the next counter position
   typedef struct packed {
      logic vbl_set;
      logic pre_clr;
   } ftg_evt_t;
endpackage

// File: rtl/ftg_raster_ctr.sv
module ftg_raster_ctr #(
   parameter int DOTS     = 341,
   parameter int LINES    = 262,
   parameter bit SKIP_ODD = 1'b1,
   parameter int DOT_W    = $clog2(DOTS),
   parameter int LINE_W   = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              render_en,
   output logic [DOT_W-1:0]  dot_q,
   output logic [LINE_W-1:0] line_q,
   output logic              odd_q,
   output logic [DOT_W-1:0]  nxt_dot,
   output logic [LINE_W-1:0] nxt_line
);
   localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
   localparam logic [DOT_W-1:0]  SKIP_DOT  = DOT_W'(DOTS - 2);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   logic short_line;
   logic wrap;
   logic frame_end;

   generate
      if (SKIP_ODD) begin : g_skip
         assign short_line = odd_q && render_en && (line_q == LAST_LINE) && (dot_q == SKIP_DOT);
      end else begin : g_noskip
         assign short_line = 1'b0;
      end
   endgenerate

   always_comb begin
      wrap      = (dot_q == LAST_DOT) || short_line;
      frame_end = wrap && (line_q == LAST_LINE);
      nxt_dot   = wrap ? '0 : dot_q + 1'b1;
      if (!wrap)          nxt_line = line_q;
      else if (frame_end) nxt_line = '0;
      else                nxt_line = line_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dot_q  <= '0;
         line_q <= '0;
         odd_q  <= 1'b0;
      end else if (dot_en) begin
         dot_q  <= nxt_dot;
         line_q <= nxt_line;
         if (frame_end) odd_q <= ~odd_q;
      end
   end
endmodule

// File: rtl/ftg_pos_decode.sv
module ftg_pos_decode
   import ftg_pkg::*;
#(
   parameter int DOT_W    = 9,
   parameter int LINE_W   = 9,
   parameter int VBL_LINE = 241,
   parameter int PRE_LINE = 261,
   parameter int FLAG_DOT = 1
) (
   input  logic [DOT_W-1:0]  nxt_dot,
   input  logic [LINE_W-1:0] nxt_line,
   output ftg_evt_t          evt
);
   localparam logic [DOT_W-1:0]  FDOT = DOT_W'(FLAG_DOT);
   localparam logic [LINE_W-1:0] VLN  = LINE_W'(VBL_LINE);
   localparam logic [LINE_W-1:0] PLN  = LINE_W'(PRE_LINE);

   always_comb begin
      evt.vbl_set = (nxt_line == VLN) && (nxt_dot == FDOT);
      evt.pre_clr = (nxt_line == PLN) && (nxt_dot == FDOT);
   end
endmodule

// File: rtl/ftg_status_flags.sv
module ftg_status_flags
   import ftg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     dot_en,
   input  ftg_evt_t evt,
   input  logic     status_rd,
   output logic     vblank_q,
   output logic     hit_clr_q
);
   logic set_ev;
   logic clr_ev;

   assign set_ev = dot_en && evt.vbl_set;
   assign clr_ev = dot_en && evt.pre_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vblank_q  <= 1'b0;
         hit_clr_q <= 1'b0;
      end else begin
         if (set_ev)                   vblank_q <= 1'b1;
         else if (clr_ev || status_rd) vblank_q <= 1'b0;
         hit_clr_q <= clr_ev;
      end
   end
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
   import ftg_pkg::*;
#(
   parameter int DOTS      = 341,
   parameter int LINES     = 262,
   parameter int VIS_LINES = 240,
   parameter int FLAG_DOT  = 1,
   parameter bit SKIP_ODD  = 1'b1,
   parameter int DOT_W     = $clog2(DOTS),
   parameter int LINE_W    = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              render_en,
   input  logic              nmi_en,
   input  logic              status_rd,
   output logic [DOT_W-1:0]  dot,
   output logic [LINE_W-1:0] line,
   output logic              visible,
   output logic              prerender,
   output logic              vblank,
   output logic              hit_clr,
   output logic              nmi_n
);
   localparam int VBL_LINE = VIS_LINES + 1;
   localparam int PRE_LINE = LINES - 1;

   generate
      if (LINES < VIS_LINES + 3) begin : g_bad_lines
         $error("frame_timing_gen: LINES too small for VIS_LINES");
      end
      if (DOTS < FLAG_DOT + 3) begin : g_bad_dots
         $error("frame_timing_gen: DOTS too small for FLAG_DOT");
      end
      if ((1 << DOT_W) < DOTS || (1 << LINE_W) < LINES) begin : g_bad_w
         $error("frame_timing_gen: counter width too narrow");
      end
   endgenerate

   logic [DOT_W-1:0]  nxt_dot;
   logic [LINE_W-1:0] nxt_line;
   logic              frame_odd;
   ftg_evt_t          evt;

   ftg_raster_ctr #(
      .DOTS(DOTS), .LINES(LINES), .SKIP_ODD(SKIP_ODD), .DOT_W(DOT_W), .LINE_W(LINE_W)
   ) ctr_i (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .render_en(render_en),
      .dot_q(dot), .line_q(line), .odd_q(frame_odd),
      .nxt_dot(nxt_dot), .nxt_line(nxt_line)
   );

   ftg_pos_decode #(
      .DOT_W(DOT_W), .LINE_W(LINE_W), .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .FLAG_DOT(FLAG_DOT)
   ) dec_i (
      .nxt_dot(nxt_dot), .nxt_line(nxt_line), .evt(evt)
   );

   ftg_status_flags flg_i (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .evt(evt), .status_rd(status_rd),
      .vblank_q(vblank), .hit_clr_q(hit_clr)
   );

   assign visible   = line < LINE_W'(VIS_LINES);
   assign prerender = line == LINE_W'(PRE_LINE);
   assign nmi_n     = ~(vblank & nmi_en);
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
   parameter int DOTS      = 341,
   parameter int LINES     = 262,
   parameter int VIS_LINES = 240,
   parameter int FLAG_DOT  = 1,
   parameter bit SKIP_ODD  = 1'b1,
   parameter int DOT_W     = 9,
   parameter int LINE_W    = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dot_en,
   input logic              render_en,
   input logic              nmi_en,
   input logic              status_rd,
   input logic [DOT_W-1:0]  dot,
   input logic [LINE_W-1:0] line,
   input logic              vblank,
   input logic              hit_clr,
   input logic              nmi_n,
   input logic              frame_odd
);
   localparam int VBL_LINE = VIS_LINES + 1;
   localparam int PRE_LINE = LINES - 1;

   p_dot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dot_en && dot == DOT_W'(DOTS - 1) |=> dot == '0);
   p_dot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dot_en |=> $stable(dot) && $stable(line));
   p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line < LINE_W'(LINES));
   p_vbl_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vblank) |-> line == LINE_W'(VBL_LINE) && dot == DOT_W'(FLAG_DOT));
   p_pre_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line == LINE_W'(PRE_LINE) && dot >= DOT_W'(FLAG_DOT) |-> !vblank);
   p_hitclr_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |-> line == LINE_W'(PRE_LINE) && dot == DOT_W'(FLAG_DOT));
   p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd && !dot_en |=> !vblank);
   p_nmi_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vblank && nmi_en |-> !nmi_n);
   p_nmi_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank |-> nmi_n);
   generate
      if (SKIP_ODD) begin : g_skip_chk
         p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
            dot_en && render_en && frame_odd && line == LINE_W'(PRE_LINE) && dot == DOT_W'(DOTS - 2)
            |=> dot == '0 && line == '0);
      end
   endgenerate
endmodule

bind frame_timing_gen ftg_checker #(
   .DOTS(DOTS), .LINES(LINES), .VIS_LINES(VIS_LINES), .FLAG_DOT(FLAG_DOT),
   .SKIP_ODD(SKIP_ODD), .DOT_W(DOT_W), .LINE_W(LINE_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .render_en(render_en), .nmi_en(nmi_en),
   .status_rd(status_rd), .dot(dot), .line(line), .vblank(vblank), .hit_clr(hit_clr),
   .nmi_n(nmi_n), .frame_odd(frame_odd)
);

// File: tb/frame_timing_gen_tb_top.sv
module frame_timing_gen_tb_top;
   localparam int DOTS   = 24;
   localparam int LINES  = 14;
   localparam int VIS    = 10;
   localparam int DOT_W  = 5;
   localparam int LINE_W = 4;
   localparam int FULL   = DOTS * LINES;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dot_en = 1'b0, render_en = 1'b1, nmi_en = 1'b0, status_rd = 1'b0;
   logic [DOT_W-1:0]  dot;
   logic [LINE_W-1:0] line;
   logic visible, prerender, vblank, hit_clr, nmi_n;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   frame_timing_gen #(.DOTS(DOTS), .LINES(LINES), .VIS_LINES(VIS), .FLAG_DOT(1),
                      .SKIP_ODD(1'b1), .DOT_W(DOT_W), .LINE_W(LINE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .render_en(render_en), .nmi_en(nmi_en),
      .status_rd(status_rd), .dot(dot), .line(line), .visible(visible),
      .prerender(prerender), .vblank(vblank), .hit_clr(hit_clr), .nmi_n(nmi_n)
   );

   // entry: line[19:12] dot[11:4] vblank visible prerender hit_clr
   localparam logic [19:0] VECS [0:10] = '{
      {8'd0,  8'd5,  4'b0100},
      {8'd9,  8'd23, 4'b0100},
      {8'd10, 8'd0,  4'b0000},
      {8'd11, 8'd0,  4'b0000},
      {8'd11, 8'd1,  4'b1000},
      {8'd12, 8'd20, 4'b1000},
      {8'd13, 8'd0,  4'b1010},
      {8'd13, 8'd1,  4'b0011},
      {8'd13, 8'd2,  4'b0010},
      {8'd13, 8'd23, 4'b0010},
      {8'd0,  8'd0,  4'b0100}
   };

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic adv_to(input int l, input int d);
      for (int n = 0; n < 4 * FULL; n++) begin
         if (int'(line) == l && int'(dot) == d) break;
         dot_en = 1'b1;
         @(negedge clk);
      end
      dot_en = 1'b0;
   endtask

   task automatic frame_len(output int n);
      n = 0;
      do begin
         dot_en = 1'b1;
         @(negedge clk);
         n++;
      end while (!(line == '0 && dot == '0) && n < 2 * FULL);
      dot_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int len;
      repeat (3) @(negedge clk);
      // R3 reset state
      chk("R3 dot", int'(dot), 0);
      chk("R3 line", int'(line), 0);
      chk("R3 vblank", int'(vblank), 0);
      chk("R3 nmi_n", int'(nmi_n), 1);
      chk("R3 hit_clr", int'(hit_clr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 hold without dot_en", int'(dot), 0);

      // table walk over frame 0 (R2, R4, R5)
      foreach (VECS[i]) begin
         adv_to(int'(VECS[i][19:12]), int'(VECS[i][11:4]));
         chk("R1/R2 position line", int'(line), int'(VECS[i][19:12]));
         chk("R1/R2 position dot", int'(dot), int'(VECS[i][11:4]));
         chk("R4/R5 vblank", int'(vblank), int'(VECS[i][3]));
         chk("R2 visible", int'(visible), int'(VECS[i][2]));
         chk("R2 prerender", int'(prerender), int'(VECS[i][1]));
         chk("R5 hit_clr", int'(hit_clr), int'(VECS[i][0]));
      end

      // R8 frame lengths, frame 1 is odd
      frame_len(len); chk("R8 odd frame render on", len, FULL - 1);
      frame_len(len); chk("R8 even frame", len, FULL);
      render_en = 1'b0;
      frame_len(len); chk("R8 odd frame render off", len, FULL);
      frame_len(len); chk("R8 even frame render off", len, FULL);
      render_en = 1'b1;
      frame_len(len); chk("R8 odd frame again", len, FULL - 1);

      // R7 immediate NMI on enable rise during vblank
      adv_to(11, 1);
      chk("R4 vblank set", int'(vblank), 1);
      chk("R7 nmi off while disabled", int'(nmi_n), 1);
      nmi_en = 1'b1;
      #1;
      chk("R7 immediate nmi", int'(nmi_n), 0);
      // R6 status read clears
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      chk("R6 read clears vblank", int'(vblank), 0);
      chk("R7 nmi released", int'(nmi_n), 1);

      // R7 nmi raised with vblank onset, held
      adv_to(11, 0);
      chk("R7 nmi before onset", int'(nmi_n), 1);
      dot_en = 1'b1;
      @(negedge clk);
      dot_en = 1'b0;
      chk("R7 nmi at onset", int'(nmi_n), 0);
      repeat (3) @(negedge clk);
      chk("R1 hold dot", int'(dot), 1);
      chk("R1 hold line", int'(line), 11);
      adv_to(12, 5);
      chk("R7 nmi held", int'(nmi_n), 0);
      nmi_en = 1'b0;
      #1;
      chk("R7 nmi follows enable", int'(nmi_n), 1);
      chk("R7 vblank unaffected", int'(vblank), 1);

      // R6 set wins over same-edge read
      adv_to(11, 0);
      dot_en = 1'b1; status_rd = 1'b1;
      @(negedge clk);
      dot_en = 1'b0; status_rd = 1'b0;
      chk("R6 set wins over read", int'(vblank), 1);

      // R3 mid-run reset restores even parity
      rst_n = 1'b0;
      @(negedge clk);
      chk("R3 vblank cleared by reset", int'(vblank), 0);
      chk("R3 line cleared by reset", int'(line), 0);
      rst_n = 1'b1;
      @(negedge clk);
      frame_len(len); chk("R3 first frame even after reset", len, FULL);
      frame_len(len); chk("R8 following frame odd", len, FULL - 1);

      finish_run();
   end
endmodule